// File: doc/BRIEF.md
# Recording-Path Automatic Gain Regulator

This block steers a 6-bit amplifier gain code so that the digitised recording signal sits near a programmed level. It receives one absolute peak magnitude per sample period on a valid/ready stream. For each accepted sample it weighs that peak against a target level and against a fixed near-full-scale danger level, then moves the gain code one step down or up once the matching timer has run out. The gain code spans -12 dB to +35.25 dB in 0.75 dB steps, so code 16 is 0 dB.

The block has two operating styles. Regulating mode raises and lowers the gain freely inside a software window. Limiter mode only pulls loud passages down and never lets the gain climb past the value it held when regulation was switched on; its timers run faster. A fast override cuts the gain on every sample whose peak is close to clipping, whatever attack setting is in force. When regulation is off, the gain freezes and software may load a new code.

The peak stream never applies back-pressure: `lvl_ready` is high at all times out of reset, and each cycle with `lvl_valid` high counts as one sample period. All control fields are plain levels and may change at any time.

Top module: `alc_engine`

## Requirements
- R1: After reset the gain code is 16 (0 dB), all timers are clear, and `lvl_ready` is high. It stays high in every cycle after reset.
- R2: The target is `(ctl_target+1) << (PW-4)`. Each valid sample with a peak above the target, but not above the fast level, advances an attack count. The gain drops one step when the count reaches the attack period. In regulating mode that period is `ATK_UNIT_REG << code` samples, with codes above 10 treated as 10.
- R3: Each valid sample with a peak at or below the target advances a decay count once the hold time has passed. The gain rises one step when the count reaches `DCY_UNIT_REG << code` samples (regulating mode).
- R4: The hold time is 0 samples for hold code 0 and `HOLD_UNIT << (code-1)` samples otherwise. Any sample above the target restarts the hold time. A sample at or below the target discards partial attack progress, and a sample above it discards partial decay progress.
- R5: A valid sample whose peak exceeds `7 << (PW-3)` (87.5 % of full scale) lowers the gain by one step on that sample and clears all timers. A peak exactly equal to that level is handled as an ordinary attack.
- R6: In limiter mode the gain never rises above the value held when regulation was enabled. The attack and decay periods use `ATK_UNIT_LIM` and `DCY_UNIT_LIM` instead.
- R7: While regulating, the window is `{ctl_min_gain,3'b000}` to `{ctl_max_gain,3'b111}`. A gain outside the window moves one step toward it on every valid sample, ahead of any level decision. Level-driven steps never leave the window.
- R8: While `ctl_enable` is low, samples are ignored and the gain is held. A pulse on `sw_gain_we` loads `sw_gain` on the next edge. A pulse on `sw_gain_we` while enabled has no effect.
- R9: In the first cycle after `ctl_enable` rises, the starting gain is captured and no step is taken. While enabled, a cycle without `lvl_valid` leaves the gain unchanged.
- R10: Apart from a software load, the gain code changes by at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_valid | input | 1 | Peak sample present; one sample period |
| lvl_ready | output | 1 | Always high out of reset |
| lvl_peak | input | PW | Absolute peak magnitude, unsigned |
| ctl_enable | input | 1 | Regulation on |
| ctl_limit_mode | input | 1 | 1 = limiter mode, 0 = regulating mode |
| ctl_target | input | 4 | Target level code |
| ctl_hold | input | 4 | Hold time code |
| ctl_attack | input | 4 | Attack period code |
| ctl_decay | input | 4 | Decay period code |
| ctl_min_gain | input | 3 | Window floor field |
| ctl_max_gain | input | 3 | Window ceiling field |
| sw_gain_we | input | 1 | Software gain load strobe |
| sw_gain | input | 6 | Software gain value |
| gain_code | output | 6 | Amplifier gain code |

## Verification
The bench aims at the places where counting goes wrong by one. These are the exact sample on which an attack or decay period ends, the hold time delaying decay by its full length, and a single loud sample in mid-hold restarting that delay. A design that miscounted would step one sample early or late, or would let the decay resume where it left off. It also probes the fast level at exactly 87.5 % and one code above it. A wrong comparison there would cut the gain on a legal peak or miss a near-clip peak. Other checks cover the limiter ceiling, gains stranded above or below the window (priority errors show as a step in the wrong direction), and software loads attempted while enabled, which a faulty design would accept.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int GAIN_W    = 6;
  localparam int CODE_W    = 4;
  localparam int WIN_W     = 3;
  localparam int MAX_SHIFT = 10;

  typedef logic [GAIN_W-1:0] gain_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    LVL_QUIET = 2'd0,
    LVL_LOUD  = 2'd1,
    LVL_CLIP  = 2'd2
  } lvl_class_e;

  function automatic code_t clamp_code(input code_t c);
    return (c > code_t'(MAX_SHIFT)) ? code_t'(MAX_SHIFT) : c;
  endfunction
endpackage

// File: rtl/alc_period_map.sv
module alc_period_map
  import alc_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int ATK_UNIT_REG = 2,
  parameter int ATK_UNIT_LIM = 1,
  parameter int DCY_UNIT_REG = 4,
  parameter int DCY_UNIT_LIM = 1,
  parameter int HOLD_UNIT    = 2
) (
  input  logic             limit_mode,
  input  code_t            atk_code,
  input  code_t            dcy_code,
  input  code_t            hold_code,
  output logic [CNT_W-1:0] atk_period,
  output logic [CNT_W-1:0] dcy_period,
  output logic [CNT_W-1:0] hold_len
);
  localparam int NSEL = 2;
  logic [CNT_W-1:0] atk_unit [NSEL];
  logic [CNT_W-1:0] dcy_unit [NSEL];

  for (genvar m = 0; m < NSEL; m++) begin : g_unit
    localparam int AU = (m == 0) ? ATK_UNIT_REG : ATK_UNIT_LIM;
    localparam int DU = (m == 0) ? DCY_UNIT_REG : DCY_UNIT_LIM;
    assign atk_unit[m] = CNT_W'(AU);
    assign dcy_unit[m] = CNT_W'(DU);
  end

  code_t a_c, d_c, h_c;
  always_comb begin
    a_c = clamp_code(atk_code);
    d_c = clamp_code(dcy_code);
    h_c = clamp_code(hold_code);
    atk_period = atk_unit[limit_mode] << a_c;
    dcy_period = dcy_unit[limit_mode] << d_c;
    if (h_c == '0) hold_len = '0;
    else           hold_len = CNT_W'(HOLD_UNIT) << (h_c - code_t'(1));
  end
endmodule

// File: rtl/alc_level_cmp.sv
module alc_level_cmp
  import alc_pkg::*;
#(
  parameter int PW = 12
) (
  input  logic [PW-1:0] peak,
  input  code_t         target_code,
  output lvl_class_e    lvl_class
);
  localparam logic [PW:0] CLIP_LVL = (PW+1)'(7) << (PW-3);
  logic [PW:0] tgt;
  always_comb begin
    tgt = (PW+1)'({1'b0, target_code} + 5'd1) << (PW-4);
    if ({1'b0, peak} > CLIP_LVL)  lvl_class = LVL_CLIP;
    else if ({1'b0, peak} > tgt)  lvl_class = LVL_LOUD;
    else                          lvl_class = LVL_QUIET;
  end
endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
  import alc_pkg::*;
#(
  parameter int    CNT_W    = 16,
  parameter gain_t RST_GAIN = gain_t'(16)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             limit_mode,
  input  logic             sample_en,
  input  lvl_class_e       lvl_class,
  input  logic [CNT_W-1:0] atk_period,
  input  logic [CNT_W-1:0] dcy_period,
  input  logic [CNT_W-1:0] hold_len,
  input  gain_t            win_lo,
  input  gain_t            win_hi,
  input  logic             sw_we,
  input  gain_t            sw_val,
  output gain_t            gain
);
  gain_t gain_q, gain_d, start_q, start_d, hi, lo;
  logic  en_q;
  logic [CNT_W-1:0] atk_q, atk_d, dcy_q, dcy_d, hold_q, hold_d;

  always_comb begin
    hi = (limit_mode && (start_q < win_hi)) ? start_q : win_hi;
    lo = (win_lo < hi) ? win_lo : hi;
  end

  always_comb begin
    gain_d  = gain_q;
    start_d = start_q;
    atk_d   = atk_q;
    dcy_d   = dcy_q;
    hold_d  = hold_q;
    if (!enable) begin
      atk_d = '0; dcy_d = '0; hold_d = '0;
      if (sw_we) gain_d = sw_val;
    end else if (!en_q) begin
      start_d = gain_q;
      atk_d = '0; dcy_d = '0; hold_d = '0;
    end else if (sample_en) begin
      if (gain_q > hi) begin
        gain_d = gain_q - gain_t'(1);
        atk_d = '0; dcy_d = '0; hold_d = '0;
      end else if (gain_q < lo) begin
        gain_d = gain_q + gain_t'(1);
        atk_d = '0; dcy_d = '0; hold_d = '0;
      end else begin
        unique case (lvl_class)
          LVL_CLIP: begin
            if (gain_q > lo) gain_d = gain_q - gain_t'(1);
            atk_d = '0; dcy_d = '0; hold_d = '0;
          end
          LVL_LOUD: begin
            dcy_d  = '0;
            hold_d = '0;
            if (atk_q >= atk_period - CNT_W'(1)) begin
              atk_d = '0;
              if (gain_q > lo) gain_d = gain_q - gain_t'(1);
            end else begin
              atk_d = atk_q + CNT_W'(1);
            end
          end
          default: begin
            atk_d = '0;
            if (hold_q < hold_len) begin
              hold_d = hold_q + CNT_W'(1);
            end else if (dcy_q >= dcy_period - CNT_W'(1)) begin
              dcy_d = '0;
              if (gain_q < hi) gain_d = gain_q + gain_t'(1);
            end else begin
              dcy_d = dcy_q + CNT_W'(1);
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q  <= RST_GAIN;
      start_q <= RST_GAIN;
      en_q    <= 1'b0;
      atk_q   <= '0;
      dcy_q   <= '0;
      hold_q  <= '0;
    end else begin
      gain_q  <= gain_d;
      start_q <= start_d;
      en_q    <= enable;
      atk_q   <= atk_d;
      dcy_q   <= dcy_d;
      hold_q  <= hold_d;
    end
  end

  assign gain = gain_q;
endmodule

// File: rtl/alc_engine.sv
module alc_engine
  import alc_pkg::*;
#(
  parameter int PW           = 12,
  parameter int CNT_W        = 16,
  parameter int ATK_UNIT_REG = 2,
  parameter int ATK_UNIT_LIM = 1,
  parameter int DCY_UNIT_REG = 4,
  parameter int DCY_UNIT_LIM = 1,
  parameter int HOLD_UNIT    = 2,
  parameter int RST_GAIN     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_valid,
  output logic          lvl_ready,
  input  logic [PW-1:0] lvl_peak,
  input  logic          ctl_enable,
  input  logic          ctl_limit_mode,
  input  logic [3:0]    ctl_target,
  input  logic [3:0]    ctl_hold,
  input  logic [3:0]    ctl_attack,
  input  logic [3:0]    ctl_decay,
  input  logic [2:0]    ctl_min_gain,
  input  logic [2:0]    ctl_max_gain,
  input  logic          sw_gain_we,
  input  logic [5:0]    sw_gain,
  output logic [5:0]    gain_code
);
  logic [CNT_W-1:0] atk_period, dcy_period, hold_len;
  lvl_class_e       lvl_class;
  gain_t            win_lo, win_hi;
  logic             rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b1;
    else        rdy_q <= 1'b1;
  end
  assign lvl_ready = rdy_q;

  assign win_lo = {ctl_min_gain, 3'b000};
  assign win_hi = {ctl_max_gain, 3'b111};

  alc_period_map #(
    .CNT_W(CNT_W), .ATK_UNIT_REG(ATK_UNIT_REG), .ATK_UNIT_LIM(ATK_UNIT_LIM),
    .DCY_UNIT_REG(DCY_UNIT_REG), .DCY_UNIT_LIM(DCY_UNIT_LIM), .HOLD_UNIT(HOLD_UNIT)
  ) u_map (
    .limit_mode(ctl_limit_mode), .atk_code(ctl_attack), .dcy_code(ctl_decay),
    .hold_code(ctl_hold), .atk_period(atk_period), .dcy_period(dcy_period),
    .hold_len(hold_len)
  );

  alc_level_cmp #(.PW(PW)) u_cmp (
    .peak(lvl_peak), .target_code(ctl_target), .lvl_class(lvl_class)
  );

  alc_gain_ctrl #(.CNT_W(CNT_W), .RST_GAIN(gain_t'(RST_GAIN))) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .limit_mode(ctl_limit_mode),
    .sample_en(lvl_valid && rdy_q), .lvl_class(lvl_class),
    .atk_period(atk_period), .dcy_period(dcy_period), .hold_len(hold_len),
    .win_lo(win_lo), .win_hi(win_hi), .sw_we(sw_gain_we), .sw_val(sw_gain),
    .gain(gain_code)
  );
endmodule

// File: rtl/alc_engine_chk.sv
module alc_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lvl_valid,
  input logic       ctl_enable,
  input logic       ctl_limit_mode,
  input logic [2:0] ctl_max_gain,
  input logic       sw_gain_we,
  input logic [5:0] gain_code
);
  logic       seen_en;
  logic [5:0] st_gain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_en <= 1'b0;
      st_gain <= 6'd0;
    end else begin
      seen_en <= ctl_enable;
      if (ctl_enable && !seen_en) st_gain <= gain_code;
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_gain_we && !ctl_enable) |=> (gain_code == $past(gain_code)) ||
      (gain_code == $past(gain_code) + 6'd1) || (gain_code == $past(gain_code) - 6'd1)); // R10

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_enable && !sw_gain_we) |=> $stable(gain_code)); // R8

  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && !lvl_valid) |=> $stable(gain_code)); // R9

  AST_LIM_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && seen_en && ctl_limit_mode && gain_code >= st_gain)
      |=> gain_code <= $past(gain_code)); // R6

  AST_ABOVE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && seen_en && lvl_valid && gain_code > {ctl_max_gain, 3'b111})
      |=> gain_code == $past(gain_code) - 6'd1); // R7
endmodule

bind alc_engine alc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_valid(lvl_valid), .ctl_enable(ctl_enable),
  .ctl_limit_mode(ctl_limit_mode), .ctl_max_gain(ctl_max_gain),
  .sw_gain_we(sw_gain_we), .gain_code(gain_code)
);

// File: tb/alc_engine_test.sv
module alc_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 12;
  localparam int NV = 10;
  localparam int V_PEAK [NV] = '{3000, 3000, 4000, 2048, 100, 3000, 100, 100, 3000, 3000};
  localparam int V_CNT  [NV] = '{8,    16,   3,    32,   64,  4,    31,  1,   4,    4};
  localparam int V_EXP  [NV] = '{15,   13,   10,   11,   13,  13,   13,  14,  14,   13};

  logic clk = 0, rst_n = 0;
  logic lvl_valid = 0, ctl_enable = 0, ctl_limit_mode = 0, sw_gain_we = 0;
  logic [PW-1:0] lvl_peak = '0;
  logic [3:0] ctl_target = 4'd7, ctl_hold = 4'd0, ctl_attack = 4'd2, ctl_decay = 4'd3;
  logic [2:0] ctl_min_gain = 3'd0, ctl_max_gain = 3'd7;
  logic [5:0] sw_gain = '0;
  logic lvl_ready;
  logic [5:0] gain_code;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alc_engine uut (
    .clk(clk), .rst_n(rst_n), .lvl_valid(lvl_valid), .lvl_ready(lvl_ready),
    .lvl_peak(lvl_peak), .ctl_enable(ctl_enable), .ctl_limit_mode(ctl_limit_mode),
    .ctl_target(ctl_target), .ctl_hold(ctl_hold), .ctl_attack(ctl_attack),
    .ctl_decay(ctl_decay), .ctl_min_gain(ctl_min_gain), .ctl_max_gain(ctl_max_gain),
    .sw_gain_we(sw_gain_we), .sw_gain(sw_gain), .gain_code(gain_code)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic send(input int pk, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lvl_valid = 1; lvl_peak = PW'(pk);
    end
    @(negedge clk); lvl_valid = 0;
  endtask

  task automatic sw_load(input int g);
    @(negedge clk); ctl_enable = 0; sw_gain_we = 1; sw_gain = 6'(g);
    @(negedge clk); sw_gain_we = 0;
  endtask

  task automatic turn_on(input logic lim);
    @(negedge clk); ctl_limit_mode = lim; ctl_enable = 1;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1 reset gain", gain_code, 16);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready high", lvl_ready, 1);

    turn_on(0);
    for (int v = 0; v < NV; v++) begin
      send(V_PEAK[v], V_CNT[v]);
      chk((v == 2) ? "R5 fast vector" : (V_PEAK[v] > 2048 ? "R2 attack vector" : "R3 decay vector"),
          gain_code, V_EXP[v]);
    end

    // R4 hold delays decay, loud sample restarts hold
    ctl_hold = 4'd2;
    send(3000, 1); send(100, 35);
    chk("R4 hold delay", gain_code, 13);
    send(100, 1);
    chk("R4 decay after hold", gain_code, 14);
    send(100, 20); send(3000, 1); send(100, 35);
    chk("R4 hold restart", gain_code, 14);
    send(100, 1);
    chk("R4 step after restart", gain_code, 15);
    ctl_hold = 4'd0;

    // R5 boundary of fast level
    send(3585, 1);
    chk("R5 above fast level", gain_code, 14);
    send(3584, 1);
    chk("R5 at fast level", gain_code, 14);

    // R6 limiter
    sw_load(20);
    chk("R8 sw load", gain_code, 20);
    turn_on(1);
    send(100, 40);
    chk("R6 no rise above start", gain_code, 20);
    send(3000, 4);
    chk("R6 fast limiter attack", gain_code, 19);
    send(100, 8);
    chk("R6 limiter decay", gain_code, 20);
    send(100, 16);
    chk("R6 capped at start", gain_code, 20);

    // R8 disabled ignores samples, sw write ignored while on
    @(negedge clk); ctl_enable = 0; ctl_limit_mode = 0;
    send(4000, 5);
    chk("R8 samples ignored off", gain_code, 20);
    turn_on(0);
    @(negedge clk); sw_gain_we = 1; sw_gain = 6'd5;
    @(negedge clk); sw_gain_we = 0;
    chk("R8 sw ignored on", gain_code, 20);

    // R7 window
    sw_load(10); ctl_min_gain = 3'd3;
    turn_on(0);
    send(4000, 3);
    chk("R7 below floor rises", gain_code, 13);
    ctl_min_gain = 3'd0;
    sw_load(40); ctl_max_gain = 3'd2;
    turn_on(0);
    send(100, 3);
    chk("R7 above ceiling falls", gain_code, 37);
    ctl_max_gain = 3'd7;
    sw_load(1);
    turn_on(0);
    send(4000, 3);
    chk("R7 floor holds at zero", gain_code, 0);

    // R9 idle cycles
    repeat (10) @(negedge clk);
    chk("R9 idle no step", gain_code, 0);
    sw_load(30);
    @(negedge clk); ctl_enable = 1; lvl_valid = 1; lvl_peak = PW'(4000);
    @(negedge clk); lvl_valid = 0;
    chk("R9 enable cycle no step", gain_code, 30);

    done = 1;
    finish_run();
  end
endmodule